// File: doc/BRIEF.md
# Newton-Raphson Reciprocal Square Root Refinement Step

This block sharpens a rough estimate of 1/sqrt(x). It takes an unsigned fixed-point operand and a seed that is already close to the reciprocal square root. It then applies one Newton-Raphson update for f(y) = 1/y² − x, which is y1 = y0·(3 − x·y0²)/2. The update uses only multiplications, one subtraction and a halving, so no divider is needed. Each iteration roughly squares the relative error of the seed. A seed within a few tenths of a percent therefore comes out at a few times 1e-5 or better.

The datapath is fully pipelined and accepts a new operand on every clock. A valid flag travels alongside the data, and the result appears four cycles after the operand. The stages are: square the seed, multiply by x, form the correction term (3 − x·y0²), and multiply by the seed delayed through the pipe with a one-bit right shift. With default parameters the operand carries 26 fraction bits and a range of (0, 4). The seed and the result share one format with 14 integer and 14 fraction bits, so outputs up to 2^13 fit.

Top module: `rsqrt_nr_step`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` is low after that edge; data registers need no reset.
- R2: `out_valid` equals `in_valid` delayed by exactly 4 rising edges, with one result per clock for back-to-back operands and gaps preserved.
- R3: With x = x_in/2^XF and y0 = seed_in/2^YF, the block forms S = seed_in², P = x_in·S and T = floor(P / 2^(XF+2·YF−TF)). It then forms E = 3·2^TF − T and the result y_out = floor(seed_in·E / 2^(TF+1)); all arithmetic is unsigned and bit-exact.
- R4: The result never exceeds 1.5 times the seed, counted in seed LSBs.
- R5: When x·y0² ≥ 3 (P ≥ 3·2^(XF+2·YF)), the correction term saturates to zero and y_out is 0.
- R6: When the result of R3 exceeds 2^YW − 1, y_out saturates to all ones.
- R7: For x in (0, 1] and a seed with relative error e, the absolute error of y1 against 1/sqrt(x) is at most (1.5e² + 0.5|e|³)/sqrt(x) + 2·2^-YF.
- R8: The relative error of y1 is at most 1.5e² + 0.5|e|³ + 2·2^-YF·sqrt(x), so the error shrinks quadratically.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand and seed are valid this cycle |
| x_in | input | XW (28) | Operand x, unsigned, XF (26) fraction bits |
| seed_in | input | YW (28) | Seed y0 ≈ 1/sqrt(x), unsigned, YF (14) fraction bits |
| out_valid | output | 1 | y_out holds a result |
| y_out | output | YW (28) | Refined y1, same format as the seed |

## Verification
The bench aims at the two saturation points and at bit-exact truncation. A seed so large that x·y0² reaches 3 must give zero; a design without that clamp would wrap the subtraction and return a huge value. With x = 0 and a large seed, the result exceeds the output range and must clamp to all ones; a design without the clamp would return the low bits of the product. Random operands are checked bit for bit, which exposes a shift that is off by one or a misaligned seed delay as a doubled or wrong-lane value. Seeds with a known error are checked against a real-valued 1/sqrt(x), which catches a wrong constant or a missing halving through the quadratic error bound. Random valid gaps and a mid-stream reset catch a pipeline that drops, duplicates or leaks valid flags.

// File: rtl/rsqrt_nr_step.sv
module rsqrt_nr_step #(
  parameter int XW = 28,
  parameter int XF = 26,
  parameter int YW = 28,
  parameter int YF = 14,
  parameter int TF = 28
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [XW-1:0] x_in,
  input  logic [YW-1:0] seed_in,
  output logic          out_valid,
  output logic [YW-1:0] y_out
);
  localparam int SW = 2 * YW;
  localparam int PW = XW + SW;
  localparam int PF = XF + 2 * YF;
  localparam int TW = TF + 2;
  localparam int MW = YW + TW;
  localparam logic [PW-1:0] THREE_P = PW'(3) << TF;
  localparam logic [TW-1:0] THREE_T = TW'(3) << TF;

  logic [3:0]    vld;
  logic [SW-1:0] sq_q;
  logic [XW-1:0] x_1;
  logic [YW-1:0] y0_1, y0_2, y0_3;
  logic [TW-1:0] t_q, e_q;
  logic [YW-1:0] y_q;

  wire [SW-1:0] sq   = {{YW{1'b0}}, seed_in} * {{YW{1'b0}}, seed_in};
  wire [PW-1:0] prod = {{SW{1'b0}}, x_1} * {{XW{1'b0}}, sq_q};
  wire [PW-1:0] ps   = prod >> (PF - TF);
  wire          clip = ps >= THREE_P;
  wire [MW-1:0] m    = {{TW{1'b0}}, y0_3} * {{YW{1'b0}}, e_q};
  wire [MW-1:0] r    = m >> (TF + 1);
  wire          ovf  = |r[MW-1:YW];

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    sq_q <= sq;
    x_1  <= x_in;
    y0_1 <= seed_in;
    t_q  <= clip ? THREE_T : ps[TW-1:0];
    y0_2 <= y0_1;
    e_q  <= THREE_T - t_q;
    y0_3 <= y0_2;
    y_q  <= ovf ? {YW{1'b1}} : r[YW-1:0];
  end

  assign out_valid = vld[3];
  assign y_out     = y_q;
endmodule

module rsqrt_nr_step_chk #(
  parameter int XW = 28,
  parameter int XF = 26,
  parameter int YW = 28,
  parameter int YF = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [XW-1:0] x_in,
  input logic [YW-1:0] seed_in,
  input logic          out_valid,
  input logic [YW-1:0] y_out
);
  localparam int PW = XW + 2 * YW;
  localparam int PF = XF + 2 * YF;
  localparam logic [PW-1:0] LIM = PW'(3) << PF;

  wire [PW-1:0] full = PW'(x_in) * PW'(seed_in) * PW'(seed_in);

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##4 out_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##4 !out_valid);

  a_r5_clip_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && full >= LIM) |-> ##4 (y_out == '0));

  a_r4_growth_bound: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##4 ({1'b0, y_out} <=
      ({1'b0, $past(seed_in, 4)} + {1'b0, ($past(seed_in, 4) >> 1)})));
endmodule

bind rsqrt_nr_step rsqrt_nr_step_chk #(.XW(XW), .XF(XF), .YW(YW), .YF(YF)) chk_i (.*);

// File: tb/rsqrt_nr_step_tb.sv
module rsqrt_nr_step_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XW = 28, XF = 26, YW = 28, YF = 14, TF = 28;
  localparam int PF = XF + 2 * YF;

  logic clk = 0, rst = 1, in_valid = 0;
  logic [XW-1:0] x_in = '0;
  logic [YW-1:0] seed_in = '0;
  logic out_valid;
  logic [YW-1:0] y_out;

  int n_run = 0, n_fail = 0;
  bit cur_acc = 0;
  string cur_tag = "R3";

  bit mv[1:4], ma[1:4];
  logic [YW-1:0] my[1:4], ms[1:4];
  logic [XW-1:0] mx[1:4];
  string mt[1:4];

  rsqrt_nr_step dut_i (.clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in),
                       .seed_in(seed_in), .out_valid(out_valid), .y_out(y_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [YW-1:0] golden(logic [XW-1:0] xv, logic [YW-1:0] yv);
    logic [127:0] sq, p, t, e, m, lim;
    lim = 128'(3) << TF;
    sq = 128'(yv) * 128'(yv);
    p = 128'(xv) * sq;
    t = p >> (PF - TF);
    if (t > lim) t = lim;
    e = lim - t;
    m = (128'(yv) * e) >> (TF + 1);
    if (m > 128'({YW{1'b1}})) return '1;
    return m[YW-1:0];
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_r(bit ok, string req, real act, real exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s error bound: actual %g expected <= %g", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i <= 4; i++) mv[i] <= 0;
    end else begin
      mv[1] <= in_valid; my[1] <= golden(x_in, seed_in); mx[1] <= x_in;
      ms[1] <= seed_in; ma[1] <= cur_acc; mt[1] <= cur_tag;
      for (int i = 2; i <= 4; i++) begin
        mv[i] <= mv[i-1]; my[i] <= my[i-1]; mx[i] <= mx[i-1];
        ms[i] <= ms[i-1]; ma[i] <= ma[i-1]; mt[i] <= mt[i-1];
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(out_valid == mv[4], "R2", "out_valid", longint'(out_valid), longint'(mv[4]));
      if (mv[4] && out_valid) begin
        chk(y_out == my[4], mt[4], "y_out", longint'(y_out), longint'(my[4]));
        if (ma[4]) begin
          real xr, tr, yr, y0r, e0, pol, rel, ab;
          xr = real'(mx[4]) / 2.0**XF;
          tr = 1.0 / $sqrt(xr);
          yr = real'(y_out) / 2.0**YF;
          y0r = real'(ms[4]) / 2.0**YF;
          e0 = y0r / tr - 1.0;
          pol = 1.5 * e0 * e0 + 0.5 * (e0 < 0 ? -e0 : e0) ** 3;
          ab = yr - tr; if (ab < 0) ab = -ab;
          rel = ab / tr;
          chk_r(ab <= tr * pol + 2.0 / 2.0**YF + 1e-12, "R7", ab, tr * pol + 2.0 / 2.0**YF);
          chk_r(rel <= pol + 2.0 * $sqrt(xr) / 2.0**YF + 1e-12, "R8", rel,
                pol + 2.0 * $sqrt(xr) / 2.0**YF);
        end
      end
    end
  end

  task automatic drive(bit v, logic [XW-1:0] xv, logic [YW-1:0] yv, string tag, bit acc);
    @(negedge clk);
    in_valid = v; x_in = xv; seed_in = yv; cur_tag = tag; cur_acc = acc;
  endtask

  task automatic drive_acc(bit v, real perr);
    logic [XW-1:0] xv;
    real tr, e0;
    xv = XW'(($urandom % (1 << XF)) + 1) >> ($urandom % 26);
    if (xv == 0) xv = 1;
    tr = 1.0 / $sqrt(real'(xv) / 2.0**XF);
    e0 = real'(int'($urandom % 2001) - 1000) / 1000.0 * perr;
    drive(v, xv, YW'($rtoi(tr * (1.0 + e0) * 2.0**YF)), "R3", 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1", "out_valid in reset", longint'(out_valid), 0);
    rst = 0;
    repeat (5) drive(0, '0, '0, "R3", 0);
    chk(out_valid == 0, "R1", "out_valid idle after reset", longint'(out_valid), 0);
    // directed corners
    drive(1, XW'(1) << XF, YW'(1) << YF, "R3", 0);
    drive(1, XW'(1) << XF, YW'(2) << YF, "R5", 0);
    drive(1, '0, YW'(1) << YF, "R3", 0);
    drive(1, '0, '1, "R6", 0);
    drive(1, XW'(1) << XF, '0, "R3", 0);
    drive(1, XW'(1), '1, "R5", 0);
    drive(1, XW'(1) << (XF - 2), YW'(2) << YF, "R3", 0);
    drive(1, XW'(3) << (XF - 2), YW'(3) << (YF - 1), "R4", 0);
    drive(0, '0, '0, "R3", 0);
    repeat (6) drive(0, '0, '0, "R3", 0);
    // back-to-back, tight seeds
    for (int i = 0; i < 400; i++) drive_acc(1, 0.003);
    // gaps, wider seeds
    for (int i = 0; i < 2500; i++) drive_acc(($urandom % 5) != 0, 0.05);
    // mid-stream reset
    drive(1, XW'(1) << XF, YW'(1) << YF, "R3", 0);
    @(negedge clk); rst = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1", "out_valid after mid reset", longint'(out_valid), 0);
    rst = 0; in_valid = 0;
    // raw bit patterns, hits both clamps
    for (int i = 0; i < 600; i++)
      drive(($urandom % 4) != 0, XW'($urandom), YW'($urandom) >> ($urandom % 28), "R3", 0);
    repeat (8) drive(0, '0, '0, "R3", 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule